// File: doc/BRIEF.md
# Circular Memory Transfer Channel with Midpoint Flag

This block is one transfer channel of a direct memory access engine. It copies a programmed number of data items from a source address to a destination address over a simple single-beat bus. Each item is one read followed by one write. It serves three kinds of traffic: a peripheral that fills memory, memory that feeds a peripheral, and a plain memory copy. The two peripheral directions move one item per peripheral request. The memory copy runs without pausing between items.

Software programs the channel through a small register port while the channel is stopped, then sets the run bit. In one-shot mode the channel stops after the last item. In ring mode it reloads the start addresses and the item count and carries on, so one buffer can be split into two halves. A sticky midpoint flag and a sticky completion flag tell software which half is ready. Each flag has its own interrupt enable.

Top module: `dma_ring_chan`

## Requirements
- R1: Direction field CTRL[3:2] is 0 = peripheral to memory, 1 = memory to peripheral, 2 = memory to memory. In the first two, one item is moved for each cycle in which `per_req` is sampled high while the channel waits, and `per_ack` is high for exactly one cycle after that item's write is accepted. In memory-to-memory copies items run back to back and `per_ack` stays low.
- R2: CTRL[4] (source) and CTRL[5] (destination) choose an incrementing (1) or fixed (0) address on each side independently. The increment equals the item size in bytes.
- R3: CTRL[7:6] selects the item size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. `mem_size` carries this code on every access, and write data keeps only the low bytes of that size, with the other bytes zero.
- R4: With CTRL[1] = 0 (one-shot), exactly the programmed count of items is written, then CTRL[0] reads 0. While stopped, COUNT reads back the programmed value.
- R5: With CTRL[1] = 1 (ring), after the last item the count and both start addresses are restored and transfers carry on. While running, COUNT reads the items left in the current pass.
- R6: STATUS[0] (midpoint) is set when the remaining count after an item equals the programmed count divided by two, rounded down. STATUS[1] (complete) is set when it reaches zero. In ring mode both are set again on every pass.
- R7: Flags stay set until software writes 1 to the flag's bit in STATUS. `irq` is high when a set flag has its enable, CTRL[8] for midpoint and CTRL[9] for complete. `irq` follows the flags one cycle later.
- R8: While the channel runs, writes to SRC, DST, COUNT and CTRL fields are ignored. The only exception is a CTRL write with bit 0 clear, which requests a stop.
- R9: After a stop request, CTRL[0] reads 1 until the item in flight has been written, then reads 0. No further item starts, even with `per_req` held high.
- R10: Setting CTRL[0] with a count of zero starts no bus access, sets no flag, and CTRL[0] reads 0.
- R11: Each bus request holds `mem_req`, `mem_addr` and `mem_we` steady until `mem_ack`. An item's read is always followed by its write.
- R12: After reset all registers and flags read 0, and `mem_req`, `per_ack` and `irq` are low. Register word indexes on `cfg_addr` are CTRL 0, SRC 1, DST 2, COUNT 3, STATUS 4. Read data appears on `cfg_rdata` the cycle after `cfg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the strobe |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | DW | Write data, right aligned |
| mem_rdata | input | DW | Read data, right aligned, valid with mem_ack |
| mem_ack | input | 1 | Access accepted |
| per_req | input | 1 | Peripheral item request, level |
| per_ack | output | 1 | One-cycle item done pulse |
| irq | output | 1 | Interrupt, enabled flags ORed |

## Verification
The assertions assume the bus answers each request with a single `mem_ack` pulse and never acknowledges when no request is pending. They also assume register writes arrive as isolated strobes rather than on consecutive cycles around a start. The bench memory model waits a few cycles and then acknowledges once, and the driver tasks always leave an idle cycle between register accesses. The peripheral model drops `per_req` in the same cycle it sees `per_ack`, which keeps the one-item-per-request rule inside what the channel expects.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

  typedef enum logic [2:0] {
    R_CTRL = 3'd0,
    R_SRC  = 3'd1,
    R_DST  = 3'd2,
    R_CNT  = 3'd3,
    R_STAT = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2
  } dir_e;

  // packed so that it maps onto CTRL[7:1]
  typedef struct packed {
    logic [1:0] width;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] dir;
    logic       circ;
  } chan_cfg_t;

  function automatic logic [2:0] step_bytes(input logic [1:0] w);
    case (w)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          busy,
  input  logic [CW-1:0] cur_cnt,
  input  logic          ht_flag,
  input  logic          tc_flag,
  output chan_cfg_t     cfg,
  output logic          ht_ie,
  output logic          tc_ie,
  output logic [AW-1:0] base_src,
  output logic [AW-1:0] base_dst,
  output logic [CW-1:0] base_cnt,
  output logic          start,
  output logic          stop_req,
  output logic          clr_ht,
  output logic          clr_tc
);

  logic lock;
  logic hit_ctrl, hit_src, hit_dst, hit_cnt, hit_stat;

  assign lock     = busy | start;
  assign hit_ctrl = cfg_wr && (cfg_addr == R_CTRL);
  assign hit_src  = cfg_wr && (cfg_addr == R_SRC);
  assign hit_dst  = cfg_wr && (cfg_addr == R_DST);
  assign hit_cnt  = cfg_wr && (cfg_addr == R_CNT);
  assign hit_stat = cfg_wr && (cfg_addr == R_STAT);

  assign clr_ht = hit_stat && cfg_wdata[0];
  assign clr_tc = hit_stat && cfg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      ht_ie    <= 1'b0;
      tc_ie    <= 1'b0;
      base_src <= '0;
      base_dst <= '0;
      base_cnt <= '0;
      start    <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      start <= 1'b0;
      if (!busy)
        stop_req <= 1'b0;
      else if (hit_ctrl && !cfg_wdata[0])
        stop_req <= 1'b1;
      if (!lock) begin
        if (hit_ctrl) begin
          cfg   <= chan_cfg_t'(cfg_wdata[7:1]);
          ht_ie <= cfg_wdata[8];
          tc_ie <= cfg_wdata[9];
          start <= cfg_wdata[0] && (base_cnt != '0);
        end
        if (hit_src) base_src <= cfg_wdata[AW-1:0];
        if (hit_dst) base_dst <= cfg_wdata[AW-1:0];
        if (hit_cnt) base_cnt <= cfg_wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      case (cfg_addr)
        R_CTRL:  cfg_rdata <= {22'd0, tc_ie, ht_ie, cfg, lock};
        R_SRC:   cfg_rdata <= 32'(base_src);
        R_DST:   cfg_rdata <= 32'(base_dst);
        R_CNT:   cfg_rdata <= 32'(busy ? cur_cnt : base_cnt);
        R_STAT:  cfg_rdata <= {30'd0, tc_flag, ht_flag};
        default: cfg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
  import dma_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop_req,
  input  chan_cfg_t     cfg,
  input  logic [AW-1:0] base_src,
  input  logic [AW-1:0] base_dst,
  input  logic [CW-1:0] base_cnt,
  input  logic          per_req,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [CW-1:0] cur_cnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  output logic          per_ack,
  output logic          ht_evt,
  output logic          tc_evt
);

  localparam int LANES = DW / 8;

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_RD, S_WR, S_GAP} st_e;
  st_e state;

  logic [AW-1:0] cur_src, cur_dst, stp;
  logic [CW-1:0] nxt, half;
  logic [DW-1:0] keep;
  logic          paced;

  assign busy  = (state != S_OFF);
  assign paced = (cfg.dir != DIR_M2M);
  assign stp   = AW'(step_bytes(cfg.width));
  assign nxt   = cur_cnt - CW'(1);
  assign half  = base_cnt >> 1;

  // byte lanes beyond the item size are cleared
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign keep[g*8 +: 8] = (32'(g) < 32'(step_bytes(cfg.width))) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_OFF;
      cur_src   <= '0;
      cur_dst   <= '0;
      cur_cnt   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      per_ack   <= 1'b0;
      ht_evt    <= 1'b0;
      tc_evt    <= 1'b0;
    end else begin
      per_ack <= 1'b0;
      ht_evt  <= 1'b0;
      tc_evt  <= 1'b0;
      unique case (state)
        S_OFF: begin
          if (start) begin
            cur_src <= base_src;
            cur_dst <= base_dst;
            cur_cnt <= base_cnt;
            state   <= S_IDLE;
          end
        end
        S_IDLE: begin
          if (stop_req) begin
            state <= S_OFF;
          end else if (!paced || per_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_src;
            mem_size <= cfg.width;
            state    <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ack) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur_dst;
            mem_wdata <= mem_rdata & keep;
            state     <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            per_ack <= paced;
            ht_evt  <= (nxt == half);
            tc_evt  <= (nxt == '0);
            if (nxt == '0) begin
              if (cfg.circ) begin
                cur_src <= base_src;
                cur_dst <= base_dst;
                cur_cnt <= base_cnt;
                state   <= S_GAP;
              end else begin
                cur_cnt <= nxt;
                state   <= S_OFF;
              end
            end else begin
              cur_cnt <= nxt;
              if (cfg.src_inc) cur_src <= cur_src + stp;
              if (cfg.dst_inc) cur_dst <= cur_dst + stp;
              state <= S_GAP;
            end
          end
        end
        S_GAP: state <= stop_req ? S_OFF : S_IDLE;
        default: state <= S_OFF;
      endcase
    end
  end

endmodule

// File: rtl/dma_ring_irq.sv
module dma_ring_irq (
  input  logic clk,
  input  logic rst,
  input  logic ht_evt,
  input  logic tc_evt,
  input  logic clr_ht,
  input  logic clr_tc,
  input  logic ht_ie,
  input  logic tc_ie,
  output logic ht_flag,
  output logic tc_flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ht_flag <= 1'b0;
      tc_flag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ht_flag <= ht_evt | (ht_flag & ~clr_ht);
      tc_flag <= tc_evt | (tc_flag & ~clr_tc);
      irq     <= (ht_flag & ht_ie) | (tc_flag & tc_ie);
    end
  end

endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
  import dma_ring_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          per_req,
  output logic          per_ack,
  output logic          irq
);

  chan_cfg_t     cfg_w;
  logic [1:0]    dir_w;
  logic          ht_ie_w, tc_ie_w, start_w, stop_w, clr_ht_w, clr_tc_w;
  logic          busy_w, ht_evt_w, tc_evt_w, ht_flag_w, tc_flag_w;
  logic [AW-1:0] base_src_w, base_dst_w;
  logic [CW-1:0] base_cnt_w, cur_cnt_w;

  assign dir_w = cfg_w.dir;

  dma_ring_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy_w), .cur_cnt(cur_cnt_w),
    .ht_flag(ht_flag_w), .tc_flag(tc_flag_w),
    .cfg(cfg_w), .ht_ie(ht_ie_w), .tc_ie(tc_ie_w),
    .base_src(base_src_w), .base_dst(base_dst_w), .base_cnt(base_cnt_w),
    .start(start_w), .stop_req(stop_w),
    .clr_ht(clr_ht_w), .clr_tc(clr_tc_w)
  );

  dma_ring_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst),
    .start(start_w), .stop_req(stop_w), .cfg(cfg_w),
    .base_src(base_src_w), .base_dst(base_dst_w), .base_cnt(base_cnt_w),
    .per_req(per_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy_w), .cur_cnt(cur_cnt_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata),
    .per_ack(per_ack), .ht_evt(ht_evt_w), .tc_evt(tc_evt_w)
  );

  dma_ring_irq u_irq (
    .clk(clk), .rst(rst),
    .ht_evt(ht_evt_w), .tc_evt(tc_evt_w),
    .clr_ht(clr_ht_w), .clr_tc(clr_tc_w),
    .ht_ie(ht_ie_w), .tc_ie(tc_ie_w),
    .ht_flag(ht_flag_w), .tc_flag(tc_flag_w), .irq(irq)
  );

endmodule

// File: rtl/dma_ring_chk.sv
module dma_ring_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic          per_ack,
  input logic          busy,
  input logic          cfg_wr,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] base_src,
  input logic [CW-1:0] cur_cnt,
  input logic [2:0]    cfg_addr,
  input logic [1:0]    dir
);

  p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_rd_then_wr_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> !per_ack);

  p_free_run_no_ack_r1: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> (dir != 2'd2));

  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_count_live_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cur_cnt != '0));

  p_src_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr && cfg_addr == 3'd1) |=> $stable(base_src));

endmodule

bind dma_ring_chan dma_ring_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .per_ack(per_ack), .busy(busy_w), .cfg_wr(cfg_wr),
  .mem_addr(mem_addr), .base_src(base_src_w), .cur_cnt(cur_cnt_w),
  .cfg_addr(cfg_addr), .dir(dir_w)
);

// File: tb/dma_ring_chan_test.sv
module dma_ring_chan_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_rd;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        per_req, per_ack, irq;

  always #5 clk = ~clk;

  dma_ring_chan uut (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .per_req(per_req), .per_ack(per_ack), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R11";

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
  } exp_t;

  exp_t        expq[$];
  logic [7:0]  mem [0:1023];
  int          wcnt;

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // memory model and scoreboard monitor
  always @(posedge clk) begin : mem_model
    exp_t        e;
    logic [31:0] v;
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt == 2) begin
        wcnt    <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          for (int i = 0; i < 4; i++)
            if (i < nbytes(mem_size))
              mem[mem_addr[9:0] + 10'(i)] = mem_wdata[i*8 +: 8];
          checks++;
          if (expq.size() == 0) begin
            errors++;
            $display("FAIL %s unexpected write: actual addr %h data %h expected no write",
                     tag, mem_addr, mem_wdata);
          end else begin
            e = expq.pop_front();
            if (mem_addr !== e.addr || mem_wdata !== e.data || mem_size !== e.size) begin
              errors++;
              $display("FAIL %s write: actual %h/%h/%0d expected %h/%h/%0d",
                       tag, mem_addr, mem_wdata, mem_size, e.addr, e.data, e.size);
            end
          end
        end else begin
          v = '0;
          for (int i = 0; i < 4; i++)
            if (i < nbytes(mem_size))
              v[i*8 +: 8] = mem[mem_addr[9:0] + 10'(i)];
          mem_rdata <= v;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string rq,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
    exp_t e;
    e.addr = a; e.data = d; e.size = s;
    expq.push_back(e);
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[i*8 +: 8];
  endtask

  task automatic per_item(output int width);
    per_req = 1'b1;
    @(negedge clk);
    while (!per_ack) @(negedge clk);
    per_req = 1'b0;
    width = 0;
    while (per_ack) begin
      width++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] ctrl(input logic en, input logic circ, input logic [1:0] dir,
                                       input logic si, input logic di, input logic [1:0] w,
                                       input logic hie, input logic tie);
    return {22'd0, tie, hie, w, di, si, dir, circ, en};
  endfunction

  initial begin : main
    logic [31:0] v, c3, c4;
    logic [31:0] pv;
    int          w;
    logic        saw;

    rst = 1'b1; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_addr = '0; cfg_wdata = '0; per_req = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(3'd0, v); check(v, 32'h0, "R12", "CTRL after reset");
    rd(3'd4, v); check(v, 32'h0, "R12", "STATUS after reset");
    check(32'(irq), 32'h0, "R12", "irq after reset");
    check(32'(mem_req), 32'h0, "R12", "mem_req after reset");

    // one-shot word copy, both sides incrementing
    tag = "R2 R3 R11";
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'h10 + i);
    for (int k = 0; k < 4; k++)
      push(32'h100 + 32'(4*k), {mem[4*k+3], mem[4*k+2], mem[4*k+1], mem[4*k]}, 2'd2);
    wr(3'd1, 32'h000); wr(3'd2, 32'h100); wr(3'd3, 32'd4);
    wr(3'd0, ctrl(1, 0, 2'd2, 1, 1, 2'd2, 1, 1));
    wait_idle();
    rd(3'd0, v); check(32'(v[0]), 32'h0, "R4", "run bit after one-shot");
    check(32'(expq.size()), 32'h0, "R4", "items left unwritten");
    rd(3'd3, v); check(v, 32'd4, "R4", "COUNT readback while stopped");
    rd(3'd4, v); check(v, 32'h3, "R6", "flags after full pass");
    repeat (2) @(negedge clk);
    check(32'(irq), 32'h1, "R7", "irq with both enabled");

    // write-one-to-clear
    wr(3'd4, 32'h1);
    rd(3'd4, v); check(v, 32'h2, "R7", "midpoint cleared only");
    repeat (2) @(negedge clk);
    check(32'(irq), 32'h1, "R7", "irq held by complete flag");
    wr(3'd4, 32'h2);
    rd(3'd4, v); check(v, 32'h0, "R7", "both cleared");
    repeat (2) @(negedge clk);
    check(32'(irq), 32'h0, "R7", "irq after clear");

    // ring mode, peripheral to memory, half-word, fixed source
    tag = "R1 R2 R3 R5";
    c3 = ctrl(1, 1, 2'd0, 0, 1, 2'd1, 1, 0);
    wr(3'd1, 32'h200); wr(3'd2, 32'h180); wr(3'd3, 32'd4);
    wr(3'd0, c3);
    for (int k = 0; k < 2; k++) begin
      pv = 32'hA5A5_1234 + 32'(k * 32'h111);
      put32(32'h200, pv);
      push(32'h180 + 32'(2*k), pv & 32'hFFFF, 2'd1);
      per_item(w);
    end
    rd(3'd4, v); check(v, 32'h1, "R6", "midpoint after two of four");
    repeat (2) @(negedge clk);
    check(32'(irq), 32'h1, "R7", "irq from midpoint enable");
    rd(3'd3, v); check(v, 32'd2, "R5", "remaining count mid pass");
    wr(3'd1, 32'h3F0);
    wr(3'd0, ctrl(1, 0, 2'd2, 1, 1, 2'd2, 0, 0));
    rd(3'd1, v); check(v, 32'h200, "R8", "SRC locked while running");
    rd(3'd0, v); check(v, c3, "R8", "CTRL locked while running");
    for (int k = 2; k < 4; k++) begin
      pv = 32'hA5A5_1234 + 32'(k * 32'h111);
      put32(32'h200, pv);
      push(32'h180 + 32'(2*k), pv & 32'hFFFF, 2'd1);
      per_item(w);
    end
    rd(3'd4, v); check(v, 32'h3, "R6", "both flags after ring pass");
    rd(3'd3, v); check(v, 32'd4, "R5", "count reloaded");
    wr(3'd4, 32'h3);
    pv = 32'h0000_BEEF;
    put32(32'h200, pv);
    push(32'h180, 32'hBEEF, 2'd1);
    per_item(w);
    rd(3'd4, v); check(v, 32'h0, "R6", "no flag after first item of pass two");
    wr(3'd0, c3 & ~32'h1);
    rd(3'd0, v); check(32'(v[0]), 32'h0, "R9", "idle ring stopped");
    check(32'(expq.size()), 32'h0, "R5", "wrapped destination written");

    // memory to peripheral, byte items, stop with an item in flight
    tag = "R1 R3 R9";
    mem[32'h40] = 8'hC1; mem[32'h41] = 8'hC2; mem[32'h42] = 8'hC3;
    c4 = ctrl(1, 0, 2'd1, 1, 0, 2'd0, 0, 0);
    wr(3'd1, 32'h040); wr(3'd2, 32'h300); wr(3'd3, 32'd3);
    wr(3'd0, c4);
    push(32'h300, 32'hC1, 2'd0);
    per_item(w);
    check(32'(w), 32'd1, "R1", "per_ack pulse length");
    push(32'h300, 32'hC2, 2'd0);
    per_req = 1'b1;
    while (!mem_req) @(negedge clk);
    wr(3'd0, c4 & ~32'h1);
    rd(3'd0, v); check(32'(v[0]), 32'h1, "R9", "run bit during in-flight item");
    while (!per_ack) @(negedge clk);
    per_req = 1'b0;
    rd(3'd0, v); check(32'(v[0]), 32'h0, "R9", "run bit after in-flight item");
    per_req = 1'b1;
    saw = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (mem_req) saw = 1'b1;
    end
    per_req = 1'b0;
    check(32'(saw), 32'h0, "R9", "no item after stop");
    check(32'(expq.size()), 32'h0, "R9", "in-flight item completed");
    rd(3'd4, v); check(v, 32'h1, "R6", "midpoint after two of three");
    check(32'(irq), 32'h0, "R7", "irq gated by enables");

    // zero count start
    tag = "R10";
    wr(3'd4, 32'h3);
    wr(3'd3, 32'd0);
    wr(3'd0, ctrl(1, 0, 2'd2, 1, 1, 2'd2, 1, 1));
    rd(3'd0, v); check(32'(v[0]), 32'h0, "R10", "run bit with zero count");
    saw = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (mem_req) saw = 1'b1;
    end
    check(32'(saw), 32'h0, "R10", "no bus access with zero count");
    rd(3'd4, v); check(v, 32'h0, "R10", "no flags with zero count");

    // single word item, both sides fixed
    tag = "R2 R3 R6";
    put32(32'h60, 32'hDEAD_BEEF);
    push(32'h380, 32'hDEAD_BEEF, 2'd2);
    wr(3'd1, 32'h060); wr(3'd2, 32'h380); wr(3'd3, 32'd1);
    wr(3'd0, ctrl(1, 0, 2'd2, 0, 0, 2'd2, 0, 0));
    wait_idle();
    rd(3'd4, v); check(v, 32'h3, "R6", "single item sets both flags");
    check(32'(expq.size()), 32'h0, "R3", "word item written");

    summary();
    $finish;
  end

endmodule